// File: doc/BRIEF.md
# Oversampled Modified Miller Decoder

This block sits behind a pause demodulator on the reader-to-card path of a contactless receiver. It takes one pause sample per strobe, four strobes per bit period, and rebuilds the framing. A pause sample seen while the decoder is idle opens a four-sample window. When that window matches the start-pause shape, the decoder reports a start of frame. It then sorts every later window into one of three symbols: a pause in the middle of the bit, no pause, or a pause at the start of the bit.

What a symbol means depends on context. A mid-bit pause always carries a one. A start-of-bit pause carries a zero only when it comes right after a zero or is the first symbol after the start of frame. A pause-free window carries a zero when it follows a one. When it follows a zero it marks the end of the frame. Because of that last rule, each decoded bit is held for one symbol before it is released. The zero that belongs to the end-of-frame sequence is then dropped and never emitted.

Illegal windows and illegal symbol orders set a sticky error flag and send the decoder back to hunting for a new start of frame. The byte and parity parsing that follows this block is not part of it.

Top module: `mm_decoder`

## Requirements
- R1: After reset, bit_valid, bit_data, sof, eof and err are all 0.
- R2: While idle, a strobe with smp_pause=1 opens a window as its sample 0. If the four samples read 1,0,0,0 in arrival order, sof pulses for one cycle, starting the cycle after the fourth strobe's clock edge.
- R3: Inside a frame, the window 0,0,1,0 (pause only at sample 2) decodes as a 1.
- R4: The window 0,0,0,0 decodes as a 0 when the previous decoded bit is a 1.
- R5: The window 1,0,0,0 decodes as a 0 when it is the first symbol after the start of frame or when the previous decoded bit is a 0.
- R6: Each decoded bit is emitted as a one-cycle bit_valid pulse with its value on bit_data, one symbol later: when the next window completes. A 0,0,0,0 window after a decoded 0 drops that held 0, pulses eof once, and ends the frame. Over a whole frame the emitted bits equal the payload in order.
- R7: Any window other than the three legal ones (for example 0,1,0,0) sets err, ends the frame and gives no eof. err then stays at 1 until reset.
- R8: A 1,0,0,0 window after a decoded 1, or a 0,0,0,0 window as the first symbol after the start of frame, sets err.
- R9: While idle, strobes with smp_pause=0 cause no output. After an eof or an error the decoder accepts and decodes a new frame.
- R10: An opening window other than 1,0,0,0 (for example 1,1,0,0) sets err and produces no sof.
- R11: Cycles with smp_valid=0 do not advance the window, so gaps of any length between strobes leave the decoded result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| smp_valid | input | 1 | Sample strobe, four per bit period |
| smp_pause | input | 1 | Sample value, 1 = pause present |
| bit_valid | output | 1 | One-cycle strobe for a decoded bit |
| bit_data | output | 1 | Decoded bit value, meaningful while bit_valid is 1 |
| sof | output | 1 | One-cycle start-of-frame strobe |
| eof | output | 1 | One-cycle end-of-frame strobe |
| err | output | 1 | Sticky error flag |

## Verification
The bench goes after the context rules that decide what a window means. If the first-bit rule were wrong, a frame starting with a zero would come out with an error or with a wrong leading bit. If the held-bit stage were wrong, the trailing zero of the end-of-frame sequence would leak out as an extra bit, or the last real bit would be lost, and the bit count would not match. Randomized frames with random gaps between strobes would catch a window counter that moves on idle cycles, since it would misalign the windows. Directed error streams show whether a misclassified window or a wrong symbol order fails to raise the flag, lets the flag drop, or leaves the decoder unable to take the next frame.

// File: rtl/mm_pkg.sv
package mm_pkg;
  typedef enum logic [1:0] {
    SYM_NONE  = 2'd0,  // no pause in the window
    SYM_MID   = 2'd1,  // pause at the middle sample
    SYM_START = 2'd2,  // pause at the first sample
    SYM_BAD   = 2'd3   // anything else
  } sym_e;
endpackage

// File: rtl/mm_window.sv
module mm_window #(
  parameter int SPB = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           smp_valid,
  input  logic           smp_pause,
  input  logic           halt,
  output logic           win_done,
  output logic [SPB-1:0] win_bits,
  output logic           busy
);
  localparam int PW = (SPB > 2) ? $clog2(SPB) : 1;
  localparam logic [PW-1:0] LAST = PW'(SPB - 1);

  logic           busy_q, busy_n;
  logic [PW-1:0]  pos_q, pos_n;
  logic [SPB-1:0] shr_q, shr_n;

  always_comb begin
    win_done = busy_q && smp_valid && (pos_q == LAST);
    win_bits = shr_q;
    win_bits[SPB-1] = smp_pause;
  end

  always_comb begin
    busy_n = busy_q;
    pos_n  = pos_q;
    shr_n  = shr_q;
    if (!busy_q) begin
      if (smp_valid && smp_pause) begin
        busy_n   = 1'b1;
        pos_n    = PW'(1);
        shr_n    = '0;
        shr_n[0] = 1'b1;
      end
    end else if (smp_valid) begin
      if (pos_q == LAST) begin
        pos_n = '0;
        shr_n = '0;
        if (halt) busy_n = 1'b0;
      end else begin
        shr_n[pos_q] = smp_pause;
        pos_n = pos_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pos_q  <= '0;
      shr_q  <= '0;
    end else begin
      busy_q <= busy_n;
      pos_q  <= pos_n;
      shr_q  <= shr_n;
    end
  end

  assign busy = busy_q;

  // R2: a window only opens on a pause sample
  p_open_on_pause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(smp_pause) && $past(smp_valid));
  // R11: no strobe, no movement of the window position
  p_hold_without_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !smp_valid) |=> $stable(pos_q));
endmodule

// File: rtl/mm_classify.sv
module mm_classify
  import mm_pkg::*;
#(
  parameter int SPB = 4
) (
  input  logic [SPB-1:0] win_bits,
  output sym_e           sym
);
  localparam logic [SPB-1:0] PAT_START = SPB'(1);
  localparam logic [SPB-1:0] PAT_MID   = SPB'(1) << (SPB / 2);

  always_comb begin
    if (win_bits == PAT_START)    sym = SYM_START;
    else if (win_bits == PAT_MID) sym = SYM_MID;
    else if (win_bits == '0)      sym = SYM_NONE;
    else                          sym = SYM_BAD;
  end
endmodule

// File: rtl/mm_context.sv
module mm_context
  import mm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic win_done,
  input  sym_e sym,
  output logic halt,
  output logic sof,
  output logic bit_valid,
  output logic bit_data,
  output logic eof,
  output logic err,
  output logic in_frame
);
  logic in_frame_q, in_frame_n;
  logic held_v_q, held_v_n;
  logic held_q, held_n;
  logic sof_q, sof_n, bv_q, bv_n, bd_q, bd_n, eof_q, eof_n, err_q, err_n;
  logic fault;

  always_comb begin
    in_frame_n = in_frame_q;
    held_v_n   = held_v_q;
    held_n     = held_q;
    sof_n      = 1'b0;
    bv_n       = 1'b0;
    bd_n       = 1'b0;
    eof_n      = 1'b0;
    err_n      = err_q;
    halt       = 1'b0;
    fault      = 1'b0;
    if (win_done) begin
      if (!in_frame_q) begin
        if (sym == SYM_START) begin
          sof_n      = 1'b1;
          in_frame_n = 1'b1;
          held_v_n   = 1'b0;
        end else begin
          fault = 1'b1;
        end
      end else begin
        unique case (sym)
          SYM_MID: begin
            bv_n     = held_v_q;
            bd_n     = held_q;
            held_n   = 1'b1;
            held_v_n = 1'b1;
          end
          SYM_START: begin
            if (!held_v_q || !held_q) begin
              bv_n     = held_v_q;
              bd_n     = held_q;
              held_n   = 1'b0;
              held_v_n = 1'b1;
            end else begin
              fault = 1'b1;
            end
          end
          SYM_NONE: begin
            if (!held_v_q) begin
              fault = 1'b1;
            end else if (held_q) begin
              bv_n   = 1'b1;
              bd_n   = 1'b1;
              held_n = 1'b0;
            end else begin
              eof_n      = 1'b1;
              halt       = 1'b1;
              in_frame_n = 1'b0;
              held_v_n   = 1'b0;
            end
          end
          default: fault = 1'b1;
        endcase
      end
      if (fault) begin
        err_n      = 1'b1;
        halt       = 1'b1;
        in_frame_n = 1'b0;
        held_v_n   = 1'b0;
        sof_n      = 1'b0;
        bv_n       = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      held_v_q   <= 1'b0;
      held_q     <= 1'b0;
      sof_q      <= 1'b0;
      bv_q       <= 1'b0;
      bd_q       <= 1'b0;
      eof_q      <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      in_frame_q <= in_frame_n;
      held_v_q   <= held_v_n;
      held_q     <= held_n;
      sof_q      <= sof_n;
      bv_q       <= bv_n;
      bd_q       <= bd_n;
      eof_q      <= eof_n;
      err_q      <= err_n;
    end
  end

  assign sof       = sof_q;
  assign bit_valid = bv_q;
  assign bit_data  = bd_q;
  assign eof       = eof_q;
  assign err       = err_q;
  assign in_frame  = in_frame_q;

  // R7: error flag never clears without reset
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  // R6: strobes are mutually exclusive
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sof_q, eof_q, bv_q}));
  // R6: eof closes an open frame
  p_eof_closes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eof_q |-> $past(in_frame_q) && !in_frame_q);
  // R2: sof opens a frame
  p_sof_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sof_q |-> in_frame_q && !$past(in_frame_q));
  // R3: bits are only released inside a frame
  p_bit_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bv_q |-> in_frame_q);
  // R7: a new error leaves the decoder idle
  p_err_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> !in_frame_q);
endmodule

// File: rtl/mm_decoder.sv
module mm_decoder
  import mm_pkg::*;
#(
  parameter int SPB = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_valid,
  input  logic smp_pause,
  output logic bit_valid,
  output logic bit_data,
  output logic sof,
  output logic eof,
  output logic err
);
  logic [1:0]     rs_q;
  logic           rst_core_n;
  logic           halt, win_done, busy, in_frame;
  logic [SPB-1:0] win_bits;
  sym_e           sym;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  mm_window #(.SPB(SPB)) u_window (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .smp_valid (smp_valid),
    .smp_pause (smp_pause),
    .halt      (halt),
    .win_done  (win_done),
    .win_bits  (win_bits),
    .busy      (busy)
  );

  mm_classify #(.SPB(SPB)) u_classify (
    .win_bits (win_bits),
    .sym      (sym)
  );

  mm_context u_context (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .win_done  (win_done),
    .sym       (sym),
    .halt      (halt),
    .sof       (sof),
    .bit_valid (bit_valid),
    .bit_data  (bit_data),
    .eof       (eof),
    .err       (err),
    .in_frame  (in_frame)
  );

  // R9: a frame in progress always has an active window
  p_frame_has_window_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    in_frame |-> busy);
endmodule

// File: tb/tb_mm_decoder.sv
module tb_mm_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic smp_pause = 1'b0;
  logic bit_valid, bit_data, sof, eof, err;

  always #5 clk = ~clk;

  mm_decoder #(.SPB(4)) dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_pause(smp_pause),
    .bit_valid(bit_valid), .bit_data(bit_data), .sof(sof), .eof(eof), .err(err)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int gapmax  = 2;
  int cap_n, sof_n, eof_n;
  bit cap [0:255];
  bit fbits [0:63];
  bit done_flag = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (bit_valid) begin
        if (cap_n < 256) cap[cap_n] = bit_data;
        cap_n++;
      end
      if (sof) sof_n++;
      if (eof) eof_n++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic smp(input bit p);
    int g;
    g = $urandom_range(0, gapmax);
    repeat (g) @(negedge clk);
    smp_valid = 1'b1;
    smp_pause = p;
    @(negedge clk);
    smp_valid = 1'b0;
    smp_pause = 1'b0;
  endtask

  // 0 = no pause, 1 = mid-bit pause, 2 = start-of-bit pause
  function automatic bit pat(input int s, input int i);
    if (s == 1) return (i == 2);
    if (s == 2) return (i == 0);
    return 1'b0;
  endfunction

  task automatic send_sym(input int s);
    for (int i = 0; i < 4; i++) smp(pat(s, i));
  endtask

  task automatic idle_gap();
    for (int i = 0; i < 4; i++) smp(1'b0);
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_cap();
    cap_n = 0; sof_n = 0; eof_n = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    smp_valid = 1'b0;
    smp_pause = 1'b0;
    repeat (3) @(negedge clk);
    clear_cap();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // encode a payload into symbols and send it with start and end
  task automatic send_frame(input int n);
    bit prev_zero;
    send_sym(2);
    prev_zero = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (fbits[i]) begin send_sym(1); prev_zero = 1'b0; end
      else if (i == 0 || prev_zero) begin send_sym(2); prev_zero = 1'b1; end
      else begin send_sym(0); prev_zero = 1'b1; end
    end
    if (prev_zero) send_sym(2); else send_sym(0);
    send_sym(0);
    idle_gap();
  endtask

  task automatic run_frame(input int n, input string tag, input bit err_exp);
    int mism;
    clear_cap();
    send_frame(n);
    mism = 0;
    for (int i = 0; i < n; i++) if (cap_n > i && cap[i] != fbits[i]) mism++;
    chk(sof_n == 1, {tag, " R2 sof count"}, sof_n, 1);
    chk(cap_n == n, {tag, " R6 bit count"}, cap_n, n);
    chk(mism == 0, {tag, " R3/R4/R5 bit values"}, mism, 0);
    chk(eof_n == 1, {tag, " R6 eof count"}, eof_n, 1);
    chk(err == err_exp, {tag, " R7 err level"}, err, err_exp);
  endtask

  initial begin
    int unsigned sd;
    int n;
    sd = $urandom(32'h0000_5eed);
    do_reset();
    // R1: reset state
    chk({bit_valid, bit_data, sof, eof, err} == 5'b0, "R1 outputs after reset",
        {bit_valid, bit_data, sof, eof, err}, 0);
    // R9: idle samples ignored
    for (int i = 0; i < 12; i++) smp(1'b0);
    repeat (3) @(negedge clk);
    chk(cap_n + sof_n + eof_n == 0, "R9 idle strobes give no output", cap_n + sof_n + eof_n, 0);
    chk(err == 1'b0, "R9 idle strobes give no error", err, 0);

    // directed frames
    fbits[0] = 1'b0; run_frame(1, "single zero R5", 1'b0);
    fbits[0] = 1'b1; run_frame(1, "single one R3", 1'b0);
    for (int i = 0; i < 8; i++) fbits[i] = 1'b0;
    run_frame(8, "all zeros R5", 1'b0);
    for (int i = 0; i < 8; i++) fbits[i] = 1'b1;
    run_frame(8, "all ones R3", 1'b0);
    for (int i = 0; i < 10; i++) fbits[i] = bit'(i % 2);
    run_frame(10, "alternating R4", 1'b0);
    // R11: long gaps between strobes
    gapmax = 7;
    for (int i = 0; i < 7; i++) fbits[i] = bit'((8'h26 >> i) & 1);
    run_frame(7, "wide gaps R11", 1'b0);
    gapmax = 2;

    // random frames
    for (int f = 0; f < 30; f++) begin
      n = $urandom_range(1, 24);
      for (int i = 0; i < n; i++) fbits[i] = bit'($urandom_range(0, 1));
      run_frame(n, "random R6", 1'b0);
    end

    // R7: illegal window inside a frame, then stickiness and recovery
    do_reset();
    send_sym(2); send_sym(1);
    smp(1'b0); smp(1'b1); smp(1'b0); smp(1'b0);
    idle_gap();
    chk(err == 1'b1, "R7 illegal window sets err", err, 1);
    chk(eof_n == 0, "R7 no eof after illegal window", eof_n, 0);
    chk(cap_n == 0, "R7 held bit dropped", cap_n, 0);
    fbits[0] = 1'b1; fbits[1] = 1'b0; fbits[2] = 1'b1;
    run_frame(3, "after error R9", 1'b1);

    // R8: start-pause after a one
    do_reset();
    send_sym(2); send_sym(1); send_sym(2);
    idle_gap();
    chk(err == 1'b1, "R8 start pause after one", err, 1);
    chk(eof_n == 0, "R8 no eof after bad order", eof_n, 0);

    // R8: pause-free first symbol
    do_reset();
    send_sym(2); send_sym(0);
    idle_gap();
    chk(sof_n == 1, "R8 sof before bad first symbol", sof_n, 1);
    chk(err == 1'b1, "R8 pause-free first symbol", err, 1);

    // R10: malformed opening window
    do_reset();
    smp(1'b1); smp(1'b1); smp(1'b0); smp(1'b0);
    idle_gap();
    chk(err == 1'b1, "R10 bad opening window sets err", err, 1);
    chk(sof_n == 0, "R10 no sof for bad opening", sof_n, 0);

    done_flag = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule